// File: doc/BRIEF.md
# Cache Entry Range Maintenance Sequencer

This block carries out one step of a restartable maintenance pass over the tag/state array of a set-associative cache. A caller issues a maintenance instruction word together with a starting entry number. The block checks the register fields of the word and takes the operation from it. It then walks entry numbers upward from the start. For each line it reads the line's state through a lookup port, may request a writeback of dirty data, and writes the new line state through an update port.

An invocation ends in one of three ways. The per-call line budget can run out, in which case the block returns the next entry to process. A dirty line can carry an uncorrectable error, in which case the block returns that entry with a machine-check status. Or the last entry can be handled, in which case the block returns all ones. Software calls the block in a loop, feeding each result back as the next start, until the result is negative. Entry e addresses set e / NWAYS and way e % NWAYS.

Top module: `cmo_entry_walker`

## Requirements
- R1: The instruction is rejected when rd [11:7] differs from rs1 [19:15], rs2 [24:20] is nonzero, funct3 [14:12] is above 3, funct7 [31:25] is nonzero, or the opcode [6:0] is not 7'b0001011. A rejected word ends with status 2'b01, result equal to the start value, and no line touched.
- R2: funct3 selects the operation: 0 clean, 1 flush, 2 discard, 3 advisory hint. The hint touches no line and requests no writeback, but the cursor still advances over its budget of entries.
- R3: The walk starts at the given entry and rises by one per handled line. Entry e is presented as set e / NWAYS and way e % NWAYS on line_set_o/line_way_o.
- R4: Clean on a valid dirty line requests a writeback, then updates the line to valid and clean. Clean leaves clean or invalid lines untouched.
- R5: Flush on a valid dirty line requests a writeback, then invalidates it. Flush invalidates a valid clean line without a writeback and leaves an invalid line untouched.
- R6: Discard invalidates every valid line it visits and never requests a writeback. Every update written by the block clears the dirty bit.
- R7: wb_req_o stays high with a stable set and way until wb_ack_i is seen. The line update and the cursor step happen only in the acknowledge cycle.
- R8: At most BUDGET lines are handled per call. When the budget runs out before the last entry, the result is the next entry number and the status is 2'b00.
- R9: After entry NSETS*NWAYS-1 is handled the result is all ones with status 2'b00; this takes precedence over budget exhaustion. A start value at or above NSETS*NWAYS, including any negative value, returns all ones at once. No other negative value is ever returned.
- R10: An uncorrectable error on a valid dirty line under clean or flush stops the walk before any writeback or update of that line. The result is that entry and the status is 2'b10; this takes precedence over budget exhaustion. The error flag is ignored on clean lines, under discard, and under hint.
- R11: done_o is high for exactly one cycle per call. start_i is accepted only while busy_o is low and is ignored otherwise.
- R12: While reset is applied, and for two cycles after it is released, busy_o is high and done_o, wb_req_o and upd_en_o are low. After that the block is idle with busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one call (sampled while idle) |
| instr_i | input | 32 | Maintenance instruction word |
| start_entry_i | input | XLEN | Entry number to resume from |
| busy_o | output | 1 | Call in progress or reset held |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 ok, 01 rejected, 10 machine check |
| result_o | output | XLEN | Next entry, fault entry, or all ones |
| line_set_o | output | SETW | Set of the current entry |
| line_way_o | output | WAYW | Way of the current entry |
| line_valid_i | input | 1 | Valid bit of the addressed line |
| line_dirty_i | input | 1 | Dirty bit of the addressed line |
| line_uerr_i | input | 1 | Uncorrectable error flag of the addressed line |
| wb_req_o | output | 1 | Writeback request for the addressed line |
| wb_ack_i | input | 1 | Writeback acknowledge |
| upd_en_o | output | 1 | Write new state to the addressed line |
| upd_valid_o | output | 1 | New valid bit (new dirty bit is always 0) |

## Verification
Three pairs of outcomes can fall on the same handled line, and each is provoked by placing the start entry so that the budget's last line coincides with the other event. In the first pair, a call starting four entries before the end exhausts the budget on the final entry, and must return all ones rather than the next number. In the second, a dirty line with an error flag placed at the budget's fourth position must return the fault entry with status 10 rather than a resume point. In the third, a writeback acknowledged on the very last entry must both clear the line and finish the walk. Each case is judged from the returned value and status, and from the line states and writeback record kept by the bench's array model.

// File: rtl/cmo_walk_pkg.sv
package cmo_walk_pkg;

  typedef enum logic [1:0] {
    OP_CLEAN   = 2'd0,
    OP_FLUSH   = 2'd1,
    OP_DISCARD = 2'd2,
    OP_HINT    = 2'd3
  } maint_op_e;

  typedef enum logic [1:0] {
    WS_OK      = 2'd0,
    WS_ILLEGAL = 2'd1,
    WS_MCHECK  = 2'd2
  } walk_status_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOOK,
    SQ_WB,
    SQ_RESP
  } seq_state_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic uerr;
  } line_state_t;

  typedef struct packed {
    logic fault;
    logic write_back;
    logic touch;
    logic keep_valid;
  } line_action_t;

  localparam int REG_W   = 5;
  localparam int OPC_LSB = 0;
  localparam int OPC_W   = 7;
  localparam int RD_LSB  = 7;
  localparam int F3_LSB  = 12;
  localparam int RS1_LSB = 15;
  localparam int RS2_LSB = 20;
  localparam int F7_LSB  = 25;
  localparam int F7_W    = 7;
  localparam logic [OPC_W-1:0] MAINT_OPCODE = 7'b0001011;

endpackage

// File: rtl/cmo_rst_sync.sv
module cmo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cmo_instr_decode.sv
module cmo_instr_decode
  import cmo_walk_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic        illegal_o,
  output maint_op_e   op_o
);
  logic [REG_W-1:0] rd_f, rs1_f, rs2_f;
  logic [2:0]       f3_f;
  logic [F7_W-1:0]  f7_f;
  logic [OPC_W-1:0] opc_f;

  always_comb begin
    rd_f  = instr_i[RD_LSB  +: REG_W];
    rs1_f = instr_i[RS1_LSB +: REG_W];
    rs2_f = instr_i[RS2_LSB +: REG_W];
    f3_f  = instr_i[F3_LSB  +: 3];
    f7_f  = instr_i[F7_LSB  +: F7_W];
    opc_f = instr_i[OPC_LSB +: OPC_W];
    // source and destination must name one register; second source unused
    illegal_o = (rd_f != rs1_f) | (|rs2_f) | f3_f[2] | (|f7_f)
              | (opc_f != MAINT_OPCODE);
    op_o = maint_op_e'(f3_f[1:0]);
  end
endmodule

// File: rtl/cmo_line_policy.sv
module cmo_line_policy
  import cmo_walk_pkg::*;
(
  input  maint_op_e    op_i,
  input  line_state_t  line_i,
  output line_action_t act_o
);
  logic keeps_data;
  logic needs_wb;

  always_comb begin
    keeps_data = (op_i == OP_CLEAN) || (op_i == OP_FLUSH);
    needs_wb   = keeps_data && line_i.valid && line_i.dirty;

    act_o.fault      = needs_wb && line_i.uerr;
    act_o.write_back = needs_wb && !line_i.uerr;
    act_o.keep_valid = (op_i == OP_CLEAN);
    // lines without a writeback: only invalidating operations change them
    unique case (op_i)
      OP_FLUSH, OP_DISCARD: act_o.touch = line_i.valid && !needs_wb;
      default:              act_o.touch = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmo_entry_cursor.sv
module cmo_entry_cursor #(
  parameter int NENT   = 32,
  parameter int BUDGET = 4,
  parameter int EW     = $clog2(NENT),
  parameter int CW     = $clog2(BUDGET + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [EW-1:0] load_entry_i,
  input  logic          step_i,
  output logic [EW-1:0] cursor_o,
  output logic          at_last_o,
  output logic          budget_last_o
);
  logic [EW-1:0] cursor_q, cursor_d;
  logic [CW-1:0] count_q, count_d;
  logic          cur_en;

  always_comb begin
    cursor_d = cursor_q;
    count_d  = count_q;
    if (load_i) begin
      cursor_d = load_entry_i;
      count_d  = '0;
    end else if (step_i) begin
      cursor_d = cursor_q + EW'(1);
      count_d  = count_q + CW'(1);
    end
    cur_en = load_i | step_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cursor_q <= '0;
      count_q  <= '0;
    end else if (cur_en) begin
      cursor_q <= cursor_d;
      count_q  <= count_d;
    end
  end

  assign cursor_o      = cursor_q;
  assign at_last_o     = (cursor_q == EW'(NENT - 1));
  assign budget_last_o = (count_q == CW'(BUDGET - 1));
endmodule

// File: rtl/cmo_entry_walker.sv
module cmo_entry_walker
  import cmo_walk_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NSETS  = 8,
  parameter int NWAYS  = 4,
  parameter int BUDGET = 4,
  parameter int SETW   = $clog2(NSETS),
  parameter int WAYW   = $clog2(NWAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] start_entry_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [1:0]      status_o,
  output logic [XLEN-1:0] result_o,
  output logic [SETW-1:0] line_set_o,
  output logic [WAYW-1:0] line_way_o,
  input  logic            line_valid_i,
  input  logic            line_dirty_i,
  input  logic            line_uerr_i,
  output logic            wb_req_o,
  input  logic            wb_ack_i,
  output logic            upd_en_o,
  output logic            upd_valid_o
);
  localparam int NENT = NSETS * NWAYS;
  localparam int EW   = SETW + WAYW;
  localparam int CW   = $clog2(BUDGET + 1);

  logic          rst_sync_n;
  logic          dec_illegal;
  maint_op_e     dec_op;
  line_state_t   line_st;
  line_action_t  act;
  logic [EW-1:0] cursor;
  logic          at_last, budget_last;

  seq_state_e        state_q, state_d;
  maint_op_e         op_q, op_d;
  logic [XLEN-1:0]   result_q, result_d;
  walk_status_e      status_q, status_d;
  logic              load, step, retire, resp_en;

  cmo_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cmo_instr_decode u_dec (
    .instr_i(instr_i), .illegal_o(dec_illegal), .op_o(dec_op)
  );

  assign line_st = '{valid: line_valid_i, dirty: line_dirty_i, uerr: line_uerr_i};

  cmo_line_policy u_pol (
    .op_i(op_q), .line_i(line_st), .act_o(act)
  );

  cmo_entry_cursor #(.NENT(NENT), .BUDGET(BUDGET), .EW(EW), .CW(CW)) u_cur (
    .clk(clk), .rst_n(rst_sync_n), .load_i(load),
    .load_entry_i(start_entry_i[EW-1:0]), .step_i(step),
    .cursor_o(cursor), .at_last_o(at_last), .budget_last_o(budget_last)
  );

  // next-state process
  always_comb begin
    state_d     = state_q;
    op_d        = op_q;
    result_d    = result_q;
    status_d    = status_q;
    load        = 1'b0;
    retire      = 1'b0;
    upd_en_o    = 1'b0;
    upd_valid_o = 1'b0;
    wb_req_o    = 1'b0;

    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          if (dec_illegal) begin
            result_d = start_entry_i;
            status_d = WS_ILLEGAL;
            state_d  = SQ_RESP;
          end else if (start_entry_i >= XLEN'(NENT)) begin
            result_d = '1;
            status_d = WS_OK;
            state_d  = SQ_RESP;
          end else begin
            load    = 1'b1;
            op_d    = dec_op;
            state_d = SQ_LOOK;
          end
        end
      end
      SQ_LOOK: begin
        if (act.fault) begin
          result_d = XLEN'(cursor);
          status_d = WS_MCHECK;
          state_d  = SQ_RESP;
        end else if (act.write_back) begin
          state_d = SQ_WB;
        end else begin
          upd_en_o    = act.touch;
          upd_valid_o = act.touch & act.keep_valid;
          retire      = 1'b1;
        end
      end
      SQ_WB: begin
        wb_req_o = 1'b1;
        if (wb_ack_i) begin
          upd_en_o    = 1'b1;
          upd_valid_o = (op_q == OP_CLEAN);
          retire      = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase

    // finishing a line: end of walk wins over budget exhaustion
    if (retire) begin
      if (at_last) begin
        result_d = '1;
        status_d = WS_OK;
        state_d  = SQ_RESP;
      end else if (budget_last) begin
        result_d = XLEN'(cursor) + XLEN'(1);
        status_d = WS_OK;
        state_d  = SQ_RESP;
      end else begin
        state_d = SQ_LOOK;
      end
    end

    step    = retire;
    resp_en = (state_d == SQ_RESP) && (state_q != SQ_RESP);
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= SQ_IDLE;
      op_q     <= OP_CLEAN;
      result_q <= '0;
      status_q <= WS_OK;
    end else begin
      state_q <= state_d;
      if (load)    op_q <= op_d;
      if (resp_en) begin
        result_q <= result_d;
        status_q <= status_d;
      end
    end
  end

  assign busy_o     = !rst_sync_n || (state_q != SQ_IDLE);
  assign done_o     = (state_q == SQ_RESP);
  assign status_o   = status_q;
  assign result_o   = result_q;
  assign line_set_o = cursor[EW-1:WAYW];
  assign line_way_o = cursor[WAYW-1:0];
endmodule

// File: rtl/cmo_entry_walker_chk.sv
module cmo_entry_walker_chk #(
  parameter int XLEN  = 32,
  parameter int NSETS = 8,
  parameter int NWAYS = 4,
  parameter int SETW  = $clog2(NSETS),
  parameter int WAYW  = $clog2(NWAYS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [4:0]      rd_f,
  input logic [4:0]      rs1_f,
  input logic            busy_o,
  input logic            done_o,
  input logic [1:0]      status_o,
  input logic [XLEN-1:0] result_o,
  input logic [SETW-1:0] line_set_o,
  input logic [WAYW-1:0] line_way_o,
  input logic            wb_req_o,
  input logic            wb_ack_i,
  input logic            upd_en_o
);
  localparam int NENT = NSETS * NWAYS;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R1
  reg_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (rd_f != rs1_f)) |=> (done_o && status_o == 2'b01));

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && !wb_ack_i) |=>
      (wb_req_o && $stable(line_set_o) && $stable(line_way_o)));

  // R9
  neg_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o != 2'b01 && result_o[XLEN-1]) |-> (&result_o));

  // R10
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == 2'b10) |-> (result_o < XLEN'(NENT)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!wb_req_o && !upd_en_o && !done_o));
endmodule

bind cmo_entry_walker cmo_entry_walker_chk #(
  .XLEN(XLEN), .NSETS(NSETS), .NWAYS(NWAYS), .SETW(SETW), .WAYW(WAYW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .rd_f(instr_i[11:7]), .rs1_f(instr_i[19:15]),
  .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .result_o(result_o),
  .line_set_o(line_set_o), .line_way_o(line_way_o),
  .wb_req_o(wb_req_o), .wb_ack_i(wb_ack_i), .upd_en_o(upd_en_o)
);

// File: tb/sim_cmo_entry_walker.sv
module sim_cmo_entry_walker;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN   = 32;
  localparam int NSETS  = 8;
  localparam int NWAYS  = 4;
  localparam int NENT   = NSETS * NWAYS;
  localparam int WDOG   = 100000;
  localparam logic [6:0] OPC = 7'b0001011;

  typedef struct packed {
    logic [31:0] vm, dm, em;
    logic [2:0]  f3;
    logic [4:0]  rd, rs1, rs2;
    logic [6:0]  opc, f7;
    logic [31:0] start;
    logic [3:0]  ack;
    logic [31:0] res;
    logic [1:0]  st;
    logic [31:0] wb, ev, ed;
  } vec_t;

  // fields: valid, dirty, error masks; funct3, rd, rs1, rs2, opcode, funct7;
  // start, ack delay; expected result, status, writeback mask, valid, dirty
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // 0 R4 R8 clean, two dirty lines, budget stop
    '{32'hFFFFFFFF, 32'h0000000A, 32'h0, 3'd0, 5'd11, 5'd11, 5'd0, OPC, 7'd0,
      32'd0, 4'd2, 32'd4, 2'd0, 32'h0000000A, 32'hFFFFFFFF, 32'h0},
    // 1 R5 flush with writebacks
    '{32'hFFFFFFFF, 32'h00000030, 32'h0, 3'd1, 5'd3, 5'd3, 5'd0, OPC, 7'd0,
      32'd4, 4'd0, 32'd8, 2'd0, 32'h00000030, 32'hFFFFFF0F, 32'h0},
    // 2 R6 R10 discard drops dirty data, error ignored
    '{32'hFFFFFFFF, 32'h00000F00, 32'h00000100, 3'd2, 5'd4, 5'd4, 5'd0, OPC, 7'd0,
      32'd8, 4'd0, 32'd12, 2'd0, 32'h0, 32'hFFFFF0FF, 32'h0},
    // 3 R2 hint advances without touching
    '{32'hFFFFFFFF, 32'h0000F000, 32'h0, 3'd3, 5'd9, 5'd9, 5'd0, OPC, 7'd0,
      32'd12, 4'd0, 32'd16, 2'd0, 32'h0, 32'hFFFFFFFF, 32'h0000F000},
    // 4 R9 last entry coincides with budget
    '{32'hFFFFFFFF, 32'h0, 32'h0, 3'd0, 5'd1, 5'd1, 5'd0, OPC, 7'd0,
      32'd28, 4'd0, 32'hFFFFFFFF, 2'd0, 32'h0, 32'hFFFFFFFF, 32'h0},
    // 5 R9 writeback acknowledged on last entry
    '{32'hFFFFFFFF, 32'h80000000, 32'h0, 3'd0, 5'd1, 5'd1, 5'd0, OPC, 7'd0,
      32'd30, 4'd1, 32'hFFFFFFFF, 2'd0, 32'h80000000, 32'hFFFFFFFF, 32'h0},
    // 6 R10 fault mid-walk under flush
    '{32'hFFFFFFFF, 32'h00040000, 32'h00040000, 3'd1, 5'd2, 5'd2, 5'd0, OPC, 7'd0,
      32'd16, 4'd0, 32'd18, 2'd2, 32'h0, 32'hFFFCFFFF, 32'h00040000},
    // 7 R10 error on clean line under clean ignored
    '{32'hFFFFFFFF, 32'h0, 32'h00100000, 3'd0, 5'd2, 5'd2, 5'd0, OPC, 7'd0,
      32'd20, 4'd0, 32'd24, 2'd0, 32'h0, 32'hFFFFFFFF, 32'h0},
    // 8 R5 R10 flush invalidates clean line with error
    '{32'hFFFFFFFF, 32'h0, 32'h01000000, 3'd1, 5'd2, 5'd2, 5'd0, OPC, 7'd0,
      32'd24, 4'd0, 32'd28, 2'd0, 32'h0, 32'hF0FFFFFF, 32'h0},
    // 9 R1 rd differs from rs1
    '{32'hFFFFFFFF, 32'h0000000F, 32'h0, 3'd0, 5'd5, 5'd6, 5'd0, OPC, 7'd0,
      32'd3, 4'd0, 32'd3, 2'd1, 32'h0, 32'hFFFFFFFF, 32'h0000000F},
    // 10 R1 rs2 nonzero
    '{32'hFFFFFFFF, 32'h0, 32'h0, 3'd1, 5'd7, 5'd7, 5'd1, OPC, 7'd0,
      32'd9, 4'd0, 32'd9, 2'd1, 32'h0, 32'hFFFFFFFF, 32'h0},
    // 11 R1 funct3 out of range
    '{32'hFFFFFFFF, 32'h0, 32'h0, 3'd5, 5'd7, 5'd7, 5'd0, OPC, 7'd0,
      32'd0, 4'd0, 32'd0, 2'd1, 32'h0, 32'hFFFFFFFF, 32'h0},
    // 12 R9 start past the array
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 3'd0, 5'd8, 5'd8, 5'd0, OPC, 7'd0,
      32'd32, 4'd0, 32'hFFFFFFFF, 2'd0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF},
    // 13 R9 negative start
    '{32'hFFFFFFFF, 32'h0, 32'h0, 3'd1, 5'd8, 5'd8, 5'd0, OPC, 7'd0,
      32'h80000000, 4'd0, 32'hFFFFFFFF, 2'd0, 32'h0, 32'hFFFFFFFF, 32'h0},
    // 14 R5 flush skips invalid dirty lines
    '{32'h0, 32'hFFFFFFFF, 32'h0, 3'd1, 5'd6, 5'd6, 5'd0, OPC, 7'd0,
      32'd0, 4'd0, 32'd4, 2'd0, 32'h0, 32'h0, 32'hFFFFFFFF},
    // 15 R10 fault on first entry
    '{32'hFFFFFFFF, 32'h1, 32'h1, 3'd0, 5'd6, 5'd6, 5'd0, OPC, 7'd0,
      32'd0, 4'd0, 32'd0, 2'd2, 32'h0, 32'hFFFFFFFF, 32'h1},
    // 16 R10 fault on the budget's last line wins
    '{32'hFFFFFFFF, 32'h80, 32'h80, 3'd0, 5'd6, 5'd6, 5'd0, OPC, 7'd0,
      32'd4, 4'd0, 32'd7, 2'd2, 32'h0, 32'hFFFFFFFF, 32'h80},
    // 17 R1 wrong opcode
    '{32'hFFFFFFFF, 32'h0, 32'h0, 3'd0, 5'd6, 5'd6, 5'd0, 7'h33, 7'd0,
      32'd2, 4'd0, 32'd2, 2'd1, 32'h0, 32'hFFFFFFFF, 32'h0},
    // 18 R1 funct7 nonzero
    '{32'hFFFFFFFF, 32'h0, 32'h0, 3'd0, 5'd6, 5'd6, 5'd0, OPC, 7'd1,
      32'd5, 4'd0, 32'd5, 2'd1, 32'h0, 32'hFFFFFFFF, 32'h0}
  };

  logic            clk, rst_n, start_i;
  logic [31:0]     instr_i;
  logic [XLEN-1:0] start_entry_i;
  logic            busy_o, done_o, wb_req_o, wb_ack_i, upd_en_o, upd_valid_o;
  logic [1:0]      status_o;
  logic [XLEN-1:0] result_o;
  logic [2:0]      line_set_o;
  logic [1:0]      line_way_o;
  logic            line_valid_i, line_dirty_i, line_uerr_i;

  logic [NENT-1:0] mv, md, me, wb_seen;
  int              ack_dly;
  int              checks, fails, cyc;
  int              idx;

  cmo_entry_walker #(.XLEN(XLEN), .NSETS(NSETS), .NWAYS(NWAYS), .BUDGET(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
    .start_entry_i(start_entry_i), .busy_o(busy_o), .done_o(done_o),
    .status_o(status_o), .result_o(result_o),
    .line_set_o(line_set_o), .line_way_o(line_way_o),
    .line_valid_i(line_valid_i), .line_dirty_i(line_dirty_i),
    .line_uerr_i(line_uerr_i), .wb_req_o(wb_req_o), .wb_ack_i(wb_ack_i),
    .upd_en_o(upd_en_o), .upd_valid_o(upd_valid_o)
  );

  // array model: entry = set * NWAYS + way (R3)
  assign idx          = int'(line_set_o) * NWAYS + int'(line_way_o);
  assign line_valid_i = mv[idx];
  assign line_dirty_i = md[idx];
  assign line_uerr_i  = me[idx];

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cyc, WDOG);
        finish_run();
      end
    end
  end

  // array write port and writeback record, registered at the clock edge
  initial begin
    forever begin
      @(posedge clk);
      if (upd_en_o) begin
        mv[idx] <= upd_valid_o;
        md[idx] <= 1'b0;
      end
      if (wb_req_o && wb_ack_i) wb_seen[idx] <= 1'b1;
    end
  end

  // writeback responder
  initial begin
    int wait_cnt;
    wb_ack_i = 1'b0;
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (wb_req_o && !wb_ack_i) begin
        if (wait_cnt >= ack_dly) wb_ack_i = 1'b1;
        else wait_cnt++;
      end else begin
        wb_ack_i = 1'b0;
        wait_cnt = 0;
      end
    end
  end

  task automatic check(input string req, input int tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s case %0d: actual %h expected %h", req, tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input logic [6:0] f7, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd,
      input logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

  task automatic run_op(input logic [31:0] ins, input logic [31:0] st);
    @(negedge clk);
    instr_i       = ins;
    start_entry_i = st;
    start_i       = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
  endtask

  task automatic load_array(input logic [31:0] v, input logic [31:0] d,
                            input logic [31:0] e);
    @(negedge clk);
    mv = v; md = d; me = e; wb_seen = '0;
  endtask

  initial begin
    logic [31:0] r;
    int          calls;
    checks = 0; fails = 0;
    start_i = 1'b0; instr_i = '0; start_entry_i = '0; ack_dly = 0;
    mv = '0; md = '0; me = '0; wb_seen = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", 100, {28'd0, busy_o, done_o, wb_req_o, upd_en_o}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", 101, {31'd0, busy_o}, 32'h1);
    repeat (2) @(negedge clk);
    check("R12", 102, {30'd0, busy_o, done_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      load_array(VECS[i].vm, VECS[i].dm, VECS[i].em);
      ack_dly = int'(VECS[i].ack);
      run_op(mk_instr(VECS[i].f7, VECS[i].rs2, VECS[i].rs1, VECS[i].f3,
                      VECS[i].rd, VECS[i].opc), VECS[i].start);
      check("R8 R9 result", i, result_o, VECS[i].res);
      check("R1 R10 status", i, {30'd0, status_o}, {30'd0, VECS[i].st});
      @(negedge clk);
      check("R11 done width", i, {31'd0, done_o}, 32'h0);
      check("R4 R7 writebacks", i, wb_seen, VECS[i].wb);
      check("R5 R6 valid", i, mv, VECS[i].ev);
      check("R2 R6 dirty", i, md, VECS[i].ed);
    end

    // R7 R3: pending writeback holds and leaves the line dirty
    load_array(32'hFFFFFFFF, 32'h4, 32'h0);
    ack_dly = 5;
    @(negedge clk);
    instr_i = mk_instr(7'd0, 5'd0, 5'd3, 3'd0, 5'd3, OPC);
    start_entry_i = 32'd0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!wb_req_o) @(negedge clk);
    check("R3 set/way", 200, {27'd0, line_set_o, line_way_o}, 32'h2);
    repeat (3) @(negedge clk);
    check("R7 held", 201, {30'd0, wb_req_o, md[2]}, 32'h3);
    // R11 start while busy is ignored
    instr_i = mk_instr(7'd0, 5'd0, 5'd4, 3'd0, 5'd3, OPC);
    start_entry_i = 32'd9;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    check("R11 ignored start", 202, result_o, 32'd4);
    check("R11 ignored start", 203, {30'd0, status_o}, 32'h0);
    @(negedge clk);
    check("R11 single done", 204, {30'd0, done_o, busy_o}, 32'h0);
    check("R7 after ack", 205, {31'd0, md[2]}, 32'h0);

    // R8 software loop over the whole array with clean
    load_array(32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0);
    ack_dly = 0;
    r = 32'd0;
    calls = 0;
    while (!r[31] && calls < 20) begin
      run_op(mk_instr(7'd0, 5'd0, 5'd10, 3'd0, 5'd10, OPC), r);
      calls++;
      if (!result_o[31])
        check("R8 resume point", 300 + calls, result_o, 32'(calls * 4));
      r = result_o;
    end
    check("R8 call count", 300, 32'(calls), 32'd8);
    check("R9 final", 330, r, 32'hFFFFFFFF);
    @(negedge clk);
    check("R4 all clean", 331, md, 32'h0);
    check("R4 all written", 332, wb_seen, 32'hFFFFFFFF);

    // R2 hint loop also terminates
    r = 32'd0;
    calls = 0;
    while (!r[31] && calls < 20) begin
      run_op(mk_instr(7'd0, 5'd0, 5'd12, 3'd3, 5'd12, OPC), r);
      calls++;
      r = result_o;
    end
    check("R2 hint calls", 340, 32'(calls), 32'd8);

    finish_run();
  end
endmodule